// File: doc/BRIEF.md
# Strap-addressed I2C control register slave

This block is an I2C target that holds a small bank of 8-bit control registers for a routing or switching datapath. It also returns a single status byte that a neighbouring block supplies. The upper six bits of its 7-bit device address are fixed at `100101`. The lowest bit is strapped from an input pin, so two copies of the block can share one bus.

A controller writes by sending the write address, then a subaddress byte, then one or more data bytes. Each data byte after the first lands in the next register. The pointer stops at 0xFF and never wraps. A controller reads by sending the read address and clocking in one byte; no subaddress is sent.

The SCL and SDA pins are oversampled by the core clock through a two-stage synchroniser. The block pulls SDA low through an open-drain enable and otherwise leaves the line released.

Top module: `i2c_cfg_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal `100101` followed by the level of `addr_sel_i`, for both R/W=0 and R/W=1. With the pin low it answers 0x94 and 0x95; with the pin high it answers 0x96 and 0x97.
- R2: For any other address byte it does not acknowledge. It then leaves SDA released and ignores all bytes until the next START, and no register changes.
- R3: In a write, the byte after the address is the subaddress and the next byte is stored in register `regs_o[8*s +: 8]`, where s is that subaddress. Every subaddress and data byte is acknowledged.
- R4: Each further data byte before STOP goes to the subaddress one higher than the previous byte.
- R5: Data bytes aimed at subaddresses 0x09 to 0xFF are acknowledged and discarded. The pointer saturates at 0xFF, so a burst starting near 0xFF never reaches register 0x00.
- R6: After reset every register bit is 0 and SDA is released.
- R7: A read returns the status byte MSB first, right after the address acknowledge. The byte is taken from `status_i` when the address byte is accepted, so changes on `status_i` during the shift do not appear until the next read.
- R8: The block changes its SDA drive only while SCL is low.
- R9: A repeated START in the middle of a byte discards the partial byte and restarts address matching.
- R10: A STOP releases SDA and ends the transfer. Bytes clocked after it without a new START get no acknowledge and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock pin level |
| sda_i | input | 1 | Bus data pin level (wired-AND line) |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_sel_i | input | 1 | Strap for the lowest device address bit |
| status_i | input | 8 | Status byte returned by reads |
| regs_o | output | 72 | Register bank, register s at bits 8*s+7 down to 8*s |

## Verification
The bench targets the auto-increment boundary and the 0xFF saturation:
- A pointer that wraps would overwrite register 0.
- A missing range check would corrupt the register bank.

For address matching, it drives write and read addresses with both strap levels. A design that ignored the strap or the R/W bit would acknowledge the wrong device.

It aborts a byte halfway with a repeated START, and clocks bytes after STOP. A design that kept its bit count would misalign the next byte, and one that ignored STOP would keep writing.

It changes the status input during a read. A design that sampled late would shift out a mixed byte.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_AACK_W,
        S_AACK_R,
        S_SUB,
        S_SACK,
        S_WDAT,
        S_DACK,
        S_RDAT,
        S_RACK
    } bus_state_e;

    typedef struct packed {
        bus_state_e st;
        logic [3:0] cnt;
        logic [7:0] sh;
        logic [7:0] tx;
        logic [7:0] ptr;
        logic       oe;
    } fsm_regs_t;

endpackage

// File: rtl/i2c_cfg_sync.sv
module i2c_cfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic start_p,
    output logic stop_p,
    output logic rise_p,
    output logic fall_p
);
    typedef struct packed {
        logic [STAGES-1:0] scl;
        logic [STAGES-1:0] sda;
        logic              scl_p;
        logic              sda_p;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.scl   = {s_q.scl[STAGES-2:0], scl_i};
        s_d.sda   = {s_q.sda[STAGES-2:0], sda_i};
        s_d.scl_p = s_q.scl[STAGES-1];
        s_d.sda_p = s_q.sda[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    logic scl_now, sda_now;
    assign scl_now = s_q.scl[STAGES-1];
    assign sda_now = s_q.sda[STAGES-1];
    assign sda_s   = sda_now;
    assign start_p = scl_now & s_q.scl_p & s_q.sda_p & ~sda_now;
    assign stop_p  = scl_now & s_q.scl_p & ~s_q.sda_p & sda_now;
    assign rise_p  = scl_now & ~s_q.scl_p;
    assign fall_p  = ~scl_now & s_q.scl_p;
endmodule

// File: rtl/i2c_cfg_regfile.sv
module i2c_cfg_regfile #(
    parameter int NUM_REGS = 9,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [7:0]            wr_data,
    output logic [NUM_REGS*8-1:0] regs_o
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [7:0] r_d, r_q;
        always_comb begin
            r_d = r_q;
            if (wr_en && (int'(wr_idx) == g)) r_d = wr_data;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r_q <= '0;
            else        r_q <= r_d;
        end
        assign regs_o[g*8 +: 8] = r_q;
    end
endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
    import i2c_cfg_pkg::*;
#(
    parameter int         NUM_REGS    = 9,
    parameter logic [5:0] DEV_ADDR_HI = 6'b100101,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    input  logic                  addr_sel_i,
    input  logic [7:0]            status_i,
    output logic [NUM_REGS*8-1:0] regs_o
);
    localparam int IDX_W = $clog2(NUM_REGS);

    logic sda_s, start_det, stop_det, scl_rise, scl_fall;
    logic wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0] wr_data;

    i2c_cfg_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .sda_s   (sda_s),
        .start_p (start_det),
        .stop_p  (stop_det),
        .rise_p  (scl_rise),
        .fall_p  (scl_fall)
    );

    fsm_regs_t f_d, f_q;

    always_comb begin
        f_d     = f_q;
        wr_en   = 1'b0;
        wr_data = f_q.sh;
        if (stop_det) begin
            f_d.st = S_IDLE;
            f_d.oe = 1'b0;
        end else if (start_det) begin
            f_d.st  = S_ADDR;
            f_d.cnt = '0;
            f_d.oe  = 1'b0;
        end else begin
            case (f_q.st)
                S_ADDR, S_SUB, S_WDAT: begin
                    if (scl_rise && f_q.cnt < 4'd8) begin
                        f_d.sh  = {f_q.sh[6:0], sda_s};
                        f_d.cnt = f_q.cnt + 4'd1;
                    end
                    if (scl_fall && f_q.cnt == 4'd8) begin
                        f_d.cnt = '0;
                        if (f_q.st == S_ADDR) begin
                            if (f_q.sh[7:1] == {DEV_ADDR_HI, addr_sel_i}) begin
                                f_d.oe = 1'b1;
                                f_d.st = f_q.sh[0] ? S_AACK_R : S_AACK_W;
                                f_d.tx = status_i;
                            end else begin
                                f_d.st = S_IDLE;
                            end
                        end else if (f_q.st == S_SUB) begin
                            f_d.ptr = f_q.sh;
                            f_d.oe  = 1'b1;
                            f_d.st  = S_SACK;
                        end else begin
                            wr_en   = (int'(f_q.ptr) < NUM_REGS);
                            f_d.ptr = (f_q.ptr == 8'hFF) ? f_q.ptr : f_q.ptr + 8'd1;
                            f_d.oe  = 1'b1;
                            f_d.st  = S_DACK;
                        end
                    end
                end
                S_AACK_W: if (scl_fall) begin
                    f_d.oe = 1'b0;
                    f_d.st = S_SUB;
                end
                S_SACK, S_DACK: if (scl_fall) begin
                    f_d.oe = 1'b0;
                    f_d.st = S_WDAT;
                end
                S_AACK_R: if (scl_fall) begin
                    f_d.oe  = ~f_q.tx[7];
                    f_d.cnt = '0;
                    f_d.st  = S_RDAT;
                end
                S_RDAT: begin
                    if (scl_rise) f_d.cnt = f_q.cnt + 4'd1;
                    if (scl_fall) begin
                        if (f_q.cnt == 4'd8) begin
                            f_d.oe = 1'b0;
                            f_d.st = S_RACK;
                        end else begin
                            f_d.tx = {f_q.tx[6:0], 1'b0};
                            f_d.oe = ~f_q.tx[6];
                        end
                    end
                end
                S_RACK: if (scl_fall) f_d.st = S_IDLE;
                default: f_d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q     <= '0;
            f_q.st  <= S_IDLE;
        end else begin
            f_q <= f_d;
        end
    end

    assign wr_idx   = f_q.ptr[IDX_W-1:0];
    assign sda_oe_o = f_q.oe;

    i2c_cfg_regfile #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .regs_o  (regs_o)
    );
endmodule

// File: rtl/i2c_cfg_slave_chk.sv
module i2c_cfg_slave_chk #(
    parameter int NUM_REGS = 9,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  sda_oe_o,
    input logic [NUM_REGS*8-1:0] regs_o,
    input logic                  wr_en,
    input logic [IDX_W-1:0]      wr_idx,
    input logic                  start_det,
    input logic                  stop_det,
    input logic                  scl_fall
);
    // R8: drive changes only follow a falling SCL or a bus condition
    assert_oe_on_low_scl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));

    assert_reset_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (regs_o == '0 && !sda_oe_o));

    assert_write_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_idx) < NUM_REGS));

    assert_write_then_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> sda_oe_o);

    assert_regs_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(regs_o));

    assert_stop_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe_o);
endmodule

bind i2c_cfg_slave i2c_cfg_slave_chk #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe_o  (sda_oe_o),
    .regs_o    (regs_o),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .start_det (start_det),
    .stop_det  (stop_det),
    .scl_fall  (scl_fall)
);

// File: tb/test_i2c_cfg_slave.sv
module test_i2c_cfg_slave;
    localparam int NR = 9;
    localparam int Q  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic addr_sel = 1'b0;
    logic [7:0] status = 8'h00;
    logic sda_oe;
    logic [NR*8-1:0] regs;
    logic [NR*8-1:0] exp_regs = '0;
    logic sda_bus;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    assign sda_bus = sda_m & ~sda_oe;

    i2c_cfg_slave i_i2c_cfg_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .sda_oe_o   (sda_oe),
        .addr_sel_i (addr_sel),
        .status_i   (status),
        .regs_o     (regs)
    );

    typedef struct packed {
        logic       pin;
        logic [7:0] addr;
        logic [7:0] sub;
        logic [7:0] data;
        logic       ack;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 8'h94, 8'h00, 8'h5A, 1'b1},
        '{1'b0, 8'h94, 8'h08, 8'hC3, 1'b1},
        '{1'b1, 8'h96, 8'h03, 8'h77, 1'b1},
        '{1'b1, 8'h94, 8'h03, 8'h11, 1'b0},
        '{1'b0, 8'h96, 8'h01, 8'h22, 1'b0},
        '{1'b1, 8'h96, 8'h0A, 8'h99, 1'b1},
        '{1'b0, 8'h90, 8'h05, 8'h66, 1'b0},
        '{1'b0, 8'h94, 8'h05, 8'hE1, 1'b1}
    };

    task automatic chk(input string req, input logic [NR*8-1:0] act, input logic [NR*8-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(1);
        scl_m = 1'b1; wq(1);
        sda_m = 1'b0; wq(1);
        scl_m = 1'b0; wq(1);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(1);
        scl_m = 1'b1; wq(1);
        sda_m = 1'b1; wq(1);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; wq(1);
            scl_m = 1'b1; wq(2);
            scl_m = 1'b0; wq(1);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; wq(1);
        scl_m = 1'b1; wq(1);
        ack = ~sda_bus; wq(1);
        scl_m = 1'b0; wq(1);
    endtask

    task automatic read_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(1); scl_m = 1'b1; wq(1);
            b[i] = sda_bus; wq(1);
            scl_m = 1'b0;
        end
        wq(1);
        sda_m = ~mack; wq(1);
        scl_m = 1'b1; wq(2);
        scl_m = 1'b0; wq(1);
        sda_m = 1'b1;
    endtask

    // R8: SDA drive must only move while the bench holds SCL low
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && sda_oe !== oe_prev) begin
            checks++;
            if (scl_m) begin
                errors++;
                $display("FAIL R8: drive changed with SCL high, actual %0b expected %0b", sda_oe, oe_prev);
            end
        end
        oe_prev = sda_oe;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic a;
        logic [7:0] rb;
        repeat (4) @(negedge clk);
        chk("R6 regs at reset", regs, '0);
        chk("R6 sda released at reset", {71'b0, sda_oe}, '0);
        rst_n = 1'b1;
        wq(2);
        chk("R6 regs after reset", regs, '0);

        // table: single-byte writes, address matching against the strap
        for (int k = 0; k < 8; k++) begin
            addr_sel = VECS[k].pin;
            wq(1);
            bus_start();
            send_byte(VECS[k].addr, a);
            chk(VECS[k].ack ? "R1 address ack" : "R2 address nack", {71'b0, a}, {71'b0, VECS[k].ack});
            send_byte(VECS[k].sub, a);
            chk("R2/R3 subaddress ack", {71'b0, a}, {71'b0, VECS[k].ack});
            send_byte(VECS[k].data, a);
            chk("R3/R5 data ack", {71'b0, a}, {71'b0, VECS[k].ack});
            bus_stop();
            if (VECS[k].ack && VECS[k].sub < NR) exp_regs[VECS[k].sub*8 +: 8] = VECS[k].data;
            wq(1);
            chk("R3/R2/R5 register bank", regs, exp_regs);
        end

        // R4 / R5: burst across the top of the bank
        addr_sel = 1'b0;
        bus_start();
        send_byte(8'h94, a);
        send_byte(8'h06, a);
        for (int k = 0; k < 5; k++) begin
            send_byte(8'hA0 + 8'(k), a);
            chk("R4/R5 burst byte ack", {71'b0, a}, 72'd1);
            if (6 + k < NR) exp_regs[(6+k)*8 +: 8] = 8'hA0 + 8'(k);
        end
        bus_stop();
        wq(1);
        chk("R4 auto-increment into 6..8, R5 beyond discarded", regs, exp_regs);

        // R5: pointer saturates at 0xFF, never wraps to register 0
        bus_start();
        send_byte(8'h94, a);
        send_byte(8'hFE, a);
        for (int k = 0; k < 4; k++) send_byte(8'h3E, a);
        chk("R5 ack at saturated pointer", {71'b0, a}, 72'd1);
        bus_stop();
        wq(1);
        chk("R5 no wrap into register 0", regs, exp_regs);

        // R7: read status, sampled at address accept
        status = 8'hA5;
        bus_start();
        send_byte(8'h95, a);
        chk("R1 read address ack", {71'b0, a}, 72'd1);
        status = 8'h3C;
        read_byte(1'b0, rb);
        bus_stop();
        chk("R7 status held during shift", {64'b0, rb}, {64'b0, 8'hA5});
        bus_start();
        send_byte(8'h95, a);
        read_byte(1'b0, rb);
        bus_stop();
        chk("R7 next read sees new status", {64'b0, rb}, {64'b0, 8'h3C});

        // R1/R2: read address of the other strap value is ignored
        bus_start();
        send_byte(8'h97, a);
        chk("R2 foreign read address nack", {71'b0, a}, 72'd0);
        read_byte(1'b0, rb);
        bus_stop();
        chk("R2 line stays released", {64'b0, rb}, {64'b0, 8'hFF});
        addr_sel = 1'b1;
        bus_start();
        send_byte(8'h97, a);
        chk("R1 read address with strap high", {71'b0, a}, 72'd1);
        read_byte(1'b0, rb);
        bus_stop();
        chk("R7 status with strap high", {64'b0, rb}, {64'b0, 8'h3C});
        addr_sel = 1'b0;

        // R9: repeated START inside a data byte
        bus_start();
        send_byte(8'h94, a);
        send_byte(8'h02, a);
        send_bits(8'hF0, 4);
        bus_start();
        send_byte(8'h94, a);
        chk("R9 address after repeated start", {71'b0, a}, 72'd1);
        send_byte(8'h03, a);
        send_byte(8'h44, a);
        bus_stop();
        exp_regs[3*8 +: 8] = 8'h44;
        wq(1);
        chk("R9 partial byte dropped, new write applied", regs, exp_regs);

        // R10: bytes after STOP without START
        send_byte(8'h94, a);
        chk("R10 no ack after stop", {71'b0, a}, 72'd0);
        send_byte(8'h00, a);
        send_byte(8'hEE, a);
        chk("R10 data ignored after stop", {71'b0, a}, 72'd0);
        bus_stop();
        wq(1);
        chk("R10 registers unchanged", regs, exp_regs);
        chk("R10 SDA released", {71'b0, sda_oe}, '0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule